// File: doc/BRIEF.md
# Audio serial clock and word-select generator

This block produces the bit clock and the word-select (frame) clock for a serial audio transmitter. It runs on a single core clock. Two single-cycle tick inputs stand for the two candidate source clocks: a system-rate tick and a PLL-rate tick. A control bit picks which of the two advances the dividers. A programmable 8-bit divider turns the selected ticks into the bit clock. An odd divisor leaves one phase one tick longer than the other, and an edge-select bit decides which phase that is. A programmable 6-bit divider counts bit-clock periods to toggle word select.

Software writes two 16-bit registers through a simple write strobe and reads them back at the same address. Divider changes made while running are held until the bit clock's next falling boundary, so no short pulse appears. The divided clock comes out as a signal. A one-cycle strobe marks each bit-clock transition so that a data shifter in the same core-clock domain can act on it. Divider codes that would mean 1 or 2 are refused: the clock stays low and a sticky error flag is raised.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, `bck_o`, `ws_o`, `bck_edge_o` and `err_o` are 0, and both registers read back as 0.
- R2: Address 0 holds the bit divider code in bits 7:0 and the word-select code in bits 13:8; bits 15:14 read as 0. Address 1 holds enable in bit 0, edge-select in bit 1 and source-select in bit 2 (0 = system tick, 1 = PLL tick); bits 15:3 read as 0. `rd_data_o` shows the register at `addr_i`.
- R3: A nonzero bit divider code N gives a bit-clock period of N selected ticks, and code 0 gives 256 ticks. An even N gives N/2 ticks low and N/2 ticks high.
- R4: For an odd N, edge-select 1 makes the high phase (N+1)/2 ticks and the low phase (N-1)/2 ticks. Edge-select 0 swaps the two. N = 3 is the smallest legal divisor.
- R5: Only ticks of the source chosen by source-select advance the dividers.
- R6: Word select starts low and toggles once every M bit-clock falling edges, where M is the 6-bit code and code 0 means 64. Each word-select phase therefore lasts M bit-clock periods.
- R7: Setting enable starts the bit clock low, and its first low phase is a full low phase: with a tick every cycle and low length L, `bck_o` first rises L+1 cycles after the cycle in which the write is accepted. Clearing enable drives `bck_o` and `ws_o` low within three cycles.
- R8: A divider code written while running takes effect only at the next bit-clock falling boundary. The period in progress completes with the old code.
- R9: Codes that mean 1 or 2 (0x01, 0x02) keep `bck_o` low and set `err_o`. `err_o` stays 1 until reset, including after a legal code resumes the clock.
- R10: While running, `bck_edge_o` is high in exactly those core-clock cycles in which `bck_o` takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sys_tick_i | input | 1 | One-cycle tick of the system-rate source |
| src_pll_tick_i | input | 1 | One-cycle tick of the PLL-rate source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address for write and read |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Read data of the addressed register |
| bck_o | output | 1 | Divided bit clock |
| ws_o | output | 1 | Word-select clock |
| bck_edge_o | output | 1 | One-cycle strobe on each bit-clock transition |
| err_o | output | 1 | Sticky illegal-divider flag |

## Verification
The assertions assume that the tick inputs are synchronous one-cycle pulses in the core-clock domain. They also assume that control writes do not re-enable the block in the cycle after a disable. The stimulus always disables the block and leaves it idle for a full write cycle before each new configuration. It also places divider writes inside a high phase, so the change lands before the falling boundary that the requirement names. The tick pattern is fixed: one tick every cycle for the system source and one every third cycle for the PLL source. With that pattern, expected phase lengths are whole cycle counts.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  localparam logic ADDR_DIV  = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int   CTRL_EN   = 0;
  localparam int   CTRL_EDGE = 1;
  localparam int   CTRL_SRC  = 2;
  localparam int   MIN_DIV   = 3;

  typedef enum logic {SRC_SYS = 1'b0, SRC_PLL = 1'b1} src_e;

  typedef struct packed {
    src_e src;
    logic edge_hi;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/acg_regs.sv
`timescale 1ns/1ps
module acg_regs
  import acg_pkg::*;
#(
  parameter int BDIV_W = 8,
  parameter int WDIV_W = 6,
  parameter int REG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic [BDIV_W-1:0] bdiv_o,
  output logic [WDIV_W-1:0] wdiv_o,
  output ctrl_t             ctrl_o
);
  localparam int FIELD_W = BDIV_W + WDIV_W;

  logic [BDIV_W-1:0] bdiv_q, bdiv_d;
  logic [WDIV_W-1:0] wdiv_q, wdiv_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data_i[REG_W-1:FIELD_W];

  always_comb begin
    bdiv_d = bdiv_q;
    wdiv_d = wdiv_q;
    ctrl_d = ctrl_q;
    if (wr_en_i && addr_i == ADDR_DIV) begin
      bdiv_d = wr_data_i[BDIV_W-1:0];
      wdiv_d = wr_data_i[BDIV_W +: WDIV_W];
    end
    if (wr_en_i && addr_i == ADDR_CTRL) begin
      ctrl_d.en      = wr_data_i[CTRL_EN];
      ctrl_d.edge_hi = wr_data_i[CTRL_EDGE];
      ctrl_d.src     = src_e'(wr_data_i[CTRL_SRC]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bdiv_q <= '0;
      wdiv_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      bdiv_q <= bdiv_d;
      wdiv_q <= wdiv_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_DIV) begin
      rd_data_o[BDIV_W-1:0]       = bdiv_q;
      rd_data_o[BDIV_W +: WDIV_W] = wdiv_q;
    end else begin
      rd_data_o[CTRL_EN]   = ctrl_q.en;
      rd_data_o[CTRL_EDGE] = ctrl_q.edge_hi;
      rd_data_o[CTRL_SRC]  = ctrl_q.src;
    end
  end

  assign bdiv_o = bdiv_q;
  assign wdiv_o = wdiv_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/acg_bclk_div.sv
`timescale 1ns/1ps
module acg_bclk_div
  import acg_pkg::*;
#(
  parameter int BDIV_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            edge_hi_i,
  input  logic [BDIV_W-1:0] code_i,
  output logic            bck_o,
  output logic            rise_o,
  output logic            fall_o,
  output logic            start_o,
  output logic            run_o,
  output logic            err_o,
  output logic [BDIV_W:0] act_n_o
);
  localparam int CNT_W = BDIV_W + 1;
  localparam logic [CNT_W-1:0] FULL_DIV = CNT_W'(1) << BDIV_W;
  localparam logic [CNT_W-1:0] MIN_N    = CNT_W'(MIN_DIV);

  logic [CNT_W-1:0] new_n, new_l;
  logic             new_bad;

  logic [CNT_W-1:0] cnt_q, cnt_d, n_q, n_d, l_q, l_d;
  logic run_q, run_d, halt_q, halt_d, bck_q, bck_d, err_q, err_d;
  logic rise_q, rise_d, fall_q, fall_d, start_q, start_d;
  logic do_load;

  // Decode the pending code: period, low length, legality.
  always_comb begin
    new_n   = (code_i == '0) ? FULL_DIV : {1'b0, code_i};
    new_l   = (new_n >> 1) + {{(CNT_W-1){1'b0}}, new_n[0] & ~edge_hi_i};
    new_bad = new_n < MIN_N;
  end

  always_comb begin
    cnt_d   = cnt_q;
    n_d     = n_q;
    l_d     = l_q;
    run_d   = run_q;
    halt_d  = halt_q;
    bck_d   = bck_q;
    err_d   = err_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    start_d = 1'b0;
    do_load = 1'b0;
    if (!en_i) begin
      run_d  = 1'b0;
      halt_d = 1'b0;
      cnt_d  = '0;
      bck_d  = 1'b0;
    end else if (!run_q) begin
      run_d   = 1'b1;
      start_d = 1'b1;
      do_load = 1'b1;
    end else if (tick_i) begin
      if (halt_q) begin
        do_load = 1'b1;
      end else if (cnt_q == n_q - 1'b1) begin
        fall_d  = 1'b1;
        do_load = 1'b1;
      end else if (cnt_q == l_q - 1'b1) begin
        bck_d  = 1'b1;
        rise_d = 1'b1;
        cnt_d  = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (do_load) begin
      cnt_d = '0;
      bck_d = 1'b0;
      if (new_bad) begin
        halt_d = 1'b1;
        err_d  = 1'b1;
      end else begin
        halt_d = 1'b0;
        n_d    = new_n;
        l_d    = new_l;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      n_q     <= '0;
      l_q     <= '0;
      run_q   <= 1'b0;
      halt_q  <= 1'b0;
      bck_q   <= 1'b0;
      err_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      n_q     <= n_d;
      l_q     <= l_d;
      run_q   <= run_d;
      halt_q  <= halt_d;
      bck_q   <= bck_d;
      err_q   <= err_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      start_q <= start_d;
    end
  end

  assign bck_o   = bck_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign start_o = start_q;
  assign run_o   = run_q;
  assign err_o   = err_q;
  assign act_n_o = n_q;
endmodule

// File: rtl/acg_ws_div.sv
`timescale 1ns/1ps
module acg_ws_div #(
  parameter int WDIV_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic [WDIV_W-1:0] code_i,
  output logic              ws_o
);
  localparam int M_W = WDIV_W + 1;
  localparam logic [M_W-1:0] FULL_M = M_W'(1) << WDIV_W;

  logic [M_W-1:0] m_new, m_q, m_d, cnt_q, cnt_d;
  logic           ws_q, ws_d, upd;

  assign m_new = (code_i == '0) ? FULL_M : {1'b0, code_i};
  assign upd   = !run_i || start_i || fall_i;

  always_comb begin
    m_d   = m_q;
    cnt_d = cnt_q;
    ws_d  = ws_q;
    if (!run_i) begin
      cnt_d = '0;
      ws_d  = 1'b0;
    end else if (start_i) begin
      m_d   = m_new;
      cnt_d = '0;
      ws_d  = 1'b0;
    end else if (fall_i) begin
      m_d = m_new;
      if (cnt_q == m_q - 1'b1) begin
        cnt_d = '0;
        ws_d  = ~ws_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q   <= '0;
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (upd) begin
      m_q   <= m_d;
      cnt_q <= cnt_d;
      ws_q  <= ws_d;
    end
  end

  assign ws_o = ws_q;
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int BDIV_W = 8,
  parameter int WDIV_W = 6,
  parameter int REG_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_sys_tick_i,
  input  logic             src_pll_tick_i,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             bck_o,
  output logic             ws_o,
  output logic             bck_edge_o,
  output logic             err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [BDIV_W-1:0] bdiv_w;
  logic [WDIV_W-1:0] wdiv_w;
  ctrl_t             ctrl_w;
  logic              tick_w, rise_w, fall_w, start_w, run_w;
  logic [BDIV_W:0]   act_n_w;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  acg_regs #(.BDIV_W(BDIV_W), .WDIV_W(WDIV_W), .REG_W(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .bdiv_o    (bdiv_w),
    .wdiv_o    (wdiv_w),
    .ctrl_o    (ctrl_w)
  );

  assign tick_w = (ctrl_w.src == SRC_PLL) ? src_pll_tick_i : src_sys_tick_i;

  acg_bclk_div #(.BDIV_W(BDIV_W)) u_bclk (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .en_i      (ctrl_w.en),
    .tick_i    (tick_w),
    .edge_hi_i (ctrl_w.edge_hi),
    .code_i    (bdiv_w),
    .bck_o     (bck_o),
    .rise_o    (rise_w),
    .fall_o    (fall_w),
    .start_o   (start_w),
    .run_o     (run_w),
    .err_o     (err_o),
    .act_n_o   (act_n_w)
  );

  acg_ws_div #(.WDIV_W(WDIV_W)) u_ws (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .run_i   (run_w),
    .start_i (start_w),
    .fall_i  (fall_w),
    .code_i  (wdiv_w),
    .ws_o    (ws_o)
  );

  assign bck_edge_o = rise_w | fall_w;
endmodule

// File: rtl/acg_checker.sv
`timescale 1ns/1ps
module acg_checker #(
  parameter int BDIV_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bck_o,
  input logic            ws_o,
  input logic            bck_edge_o,
  input logic            err_o,
  input logic            run_i,
  input logic            fall_i,
  input logic [BDIV_W:0] act_n_i
);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_legal_when_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bck_o |-> (act_n_i >= 3));

  assert_idle_bck_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !bck_o);

  assert_idle_ws_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !ws_o);

  assert_edge_marks_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bck_edge_o |-> (bck_o != $past(bck_o)));

  assert_change_marked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (bck_o != $past(bck_o))) |-> bck_edge_o);

  assert_ws_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (ws_o != $past(ws_o))) |-> $past(fall_i));
endmodule

bind audio_clkgen acg_checker #(.BDIV_W(BDIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n_s),
  .bck_o      (bck_o),
  .ws_o       (ws_o),
  .bck_edge_o (bck_edge_o),
  .err_o      (err_o),
  .run_i      (run_w),
  .fall_i     (fall_w),
  .act_n_i    (act_n_w)
);

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_sys_tick_i = 1'b1;
  logic        src_pll_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        bck_o, ws_o, bck_edge_o, err_o;

  audio_clkgen u_dut (
    .clk_i, .rst_ni, .src_sys_tick_i, .src_pll_tick_i, .wr_en_i, .addr_i,
    .wr_data_i, .rd_data_o, .bck_o, .ws_o, .bck_edge_o, .err_o
  );

  always #2 clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // PLL-rate source: one tick every third cycle.
  int pll_k = 0;
  initial forever begin
    @(negedge clk_i);
    pll_k++;
    src_pll_tick_i = (pll_k % 3 == 0);
  end

  // Scoreboard queues: expected phase lengths in core cycles.
  int    qb_len[$]; bit qb_hi[$]; string qb_tag[$];
  int    qw_len[$]; bit qw_hi[$]; string qw_tag[$];
  bit    mon_arm = 0;
  int    cyc = 0;
  int    b_t, w_t, e_len;
  bit    b_valid, w_valid, b_prev, w_prev, e_hi;
  string e_tag;

  task automatic push_b(bit hi, int len, string tag);
    qb_hi.push_back(hi); qb_len.push_back(len); qb_tag.push_back(tag);
  endtask
  task automatic push_w(bit hi, int len, string tag);
    qw_hi.push_back(hi); qw_len.push_back(len); qw_tag.push_back(tag);
  endtask
  task automatic push_pairs(int hi_len, int lo_len, int n, string tag);
    for (int i = 0; i < n; i++) begin
      push_b(1'b1, hi_len, tag);
      push_b(1'b0, lo_len, tag);
    end
  endtask

  // Monitor: measures full phases and compares with the queue heads.
  always @(negedge clk_i) begin
    cyc++;
    if (!mon_arm) begin
      b_valid = 0;
      w_valid = 0;
    end else begin
      if (bck_o !== b_prev) begin
        if (b_valid && qb_len.size() > 0) begin
          e_len = qb_len.pop_front(); e_hi = qb_hi.pop_front(); e_tag = qb_tag.pop_front();
          chk((cyc - b_t) == e_len && b_prev == e_hi, e_tag, cyc - b_t, e_len);
        end
        b_valid = 1;
        b_t = cyc;
      end
      if (ws_o !== w_prev) begin
        if (w_valid && qw_len.size() > 0) begin
          e_len = qw_len.pop_front(); e_hi = qw_hi.pop_front(); e_tag = qw_tag.pop_front();
          chk((cyc - w_t) == e_len && w_prev == e_hi, e_tag, cyc - w_t, e_len);
        end
        w_valid = 1;
        w_t = cyc;
      end
    end
    b_prev = bck_o;
    w_prev = ws_o;
  end

  task automatic wr(logic a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic drain(string tag);
    int k = 0;
    while ((qb_len.size() > 0 || qw_len.size() > 0) && k < 6000) begin
      @(negedge clk_i);
      k++;
    end
    chk(qb_len.size() == 0 && qw_len.size() == 0, tag, qb_len.size() + qw_len.size(), 0);
    qb_len.delete(); qb_hi.delete(); qb_tag.delete();
    qw_len.delete(); qw_hi.delete(); qw_tag.delete();
  endtask

  task automatic cfg(logic [7:0] n, logic [5:0] m, bit edge_hi, bit src);
    mon_arm = 0;
    wr(1'b1, 16'h0000);
    wr(1'b0, {2'b00, m, n});
    wr(1'b1, {13'b0, src, edge_hi, 1'b1});
    mon_arm = 1;
  endtask

  initial begin
    #600000;
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n, pulses, changes, stray;
    bit seen_hi, prev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R1 reset state
    chk(bck_o == 0 && ws_o == 0, "R1 clocks low", {bck_o, ws_o}, 0);
    chk(bck_edge_o == 0 && err_o == 0, "R1 strobe and error low", {bck_edge_o, err_o}, 0);
    rd(1'b0, d); chk(d == 16'h0, "R1 divider reg", d, 0);
    rd(1'b1, d); chk(d == 16'h0, "R1 control reg", d, 0);

    // R2 register layout and readback
    wr(1'b0, 16'hC305);
    rd(1'b0, d); chk(d == 16'h0305, "R2 divider readback", d, 16'h0305);
    wr(1'b1, 16'hFFF2);
    rd(1'b1, d); chk(d == 16'h0002, "R2 control readback", d, 2);
    chk(bck_o == 0, "R2 enable bit clear keeps idle", bck_o, 0);

    // R3 even divider 4, R6 word select every 3 periods, R7 start latency
    cfg(8'd4, 6'd3, 1'b0, 1'b0);
    push_pairs(2, 2, 3, "R3 even divide by 4");
    push_w(1'b1, 12, "R6 ws M=3"); push_w(1'b0, 12, "R6 ws M=3");
    n = 0;
    while (bck_o == 0 && n < 50) begin @(negedge clk_i); n++; end
    chk(n == 3, "R7 first low phase length", n, 3);
    drain("R3 drain");

    // R10 edge strobe matches each transition
    pulses = 0; changes = 0; stray = 0; prev = bck_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (bck_o != prev) changes++;
      if (bck_edge_o) pulses++;
      if (bck_edge_o && bck_o == prev) stray++;
      prev = bck_o;
    end
    chk(pulses == changes && stray == 0 && changes == 20, "R10 strobe count", pulses, changes);

    // R4 odd divisors, both edge settings
    cfg(8'd5, 6'd1, 1'b1, 1'b0);
    push_pairs(3, 2, 2, "R4 odd 5 high long");
    push_w(1'b1, 5, "R6 ws M=1");
    drain("R4 drain a");
    cfg(8'd5, 6'd1, 1'b0, 1'b0);
    push_pairs(2, 3, 2, "R4 odd 5 low long");
    drain("R4 drain b");
    cfg(8'd3, 6'd1, 1'b0, 1'b0);
    push_pairs(1, 2, 2, "R4 minimum divisor 3");
    drain("R4 drain c");

    // R3 code 0 means 256
    cfg(8'd0, 6'd1, 1'b0, 1'b0);
    push_pairs(128, 128, 1, "R3 code zero as 256");
    push_w(1'b1, 256, "R6 ws with 256");
    drain("R3 drain 256");

    // R6 word-select code 0 means 64
    cfg(8'd3, 6'd0, 1'b1, 1'b0);
    push_w(1'b1, 192, "R6 ws code zero as 64"); push_w(1'b0, 192, "R6 ws code zero as 64");
    drain("R6 drain");

    // R5 PLL source: one tick every 3 cycles
    cfg(8'd4, 6'd1, 1'b0, 1'b1);
    push_pairs(6, 6, 2, "R5 PLL source");
    drain("R5 drain");

    // R8 change while running takes effect at falling boundary
    cfg(8'd6, 6'd1, 1'b0, 1'b0);
    n = 0;
    while (bck_o != 0 && n < 100) begin @(negedge clk_i); n++; end
    while (bck_o != 1 && n < 100) begin @(negedge clk_i); n++; end
    @(posedge clk_i); #1;
    push_b(1'b1, 3, "R8 old high completes");
    push_b(1'b0, 5, "R8 new low");
    push_b(1'b1, 5, "R8 new high");
    push_b(1'b0, 5, "R8 new low");
    wr(1'b0, {2'b00, 6'd1, 8'd10});
    drain("R8 drain");

    // R7 disable returns outputs low
    n = 0;
    while (!(bck_o && ws_o) && n < 200) begin @(negedge clk_i); n++; end
    mon_arm = 0;
    wr(1'b1, 16'h0000);
    repeat (3) @(negedge clk_i);
    chk(bck_o == 0 && ws_o == 0, "R7 disable drives low", {bck_o, ws_o}, 0);

    // R9 illegal codes
    chk(err_o == 0, "R9 no error before illegal code", err_o, 0);
    wr(1'b0, {2'b00, 6'd1, 8'd1});
    wr(1'b1, 16'h0001);
    seen_hi = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk_i); if (bck_o) seen_hi = 1; end
    chk(seen_hi == 0, "R9 code 1 keeps clock low", seen_hi, 0);
    chk(err_o == 1, "R9 code 1 raises error", err_o, 1);
    wr(1'b1, 16'h0000);
    wr(1'b0, {2'b00, 6'd1, 8'd4});
    wr(1'b1, 16'h0001);
    seen_hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk_i); if (bck_o) seen_hi = 1; end
    chk(seen_hi == 1, "R9 legal code resumes", seen_hi, 1);
    chk(err_o == 1, "R9 error sticky", err_o, 1);
    wr(1'b0, {2'b00, 6'd1, 8'd2});
    repeat (10) @(negedge clk_i);
    seen_hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk_i); if (bck_o) seen_hi = 1; end
    chk(seen_hi == 0, "R9 code 2 stops clock", seen_hi, 0);
    chk(err_o == 1, "R9 error after code 2", err_o, 1);

    summary();
    $finish;
  end
endmodule